// File: doc/BRIEF.md
# Black-level clamp servo

This block is a digital servo that keeps the black level of an image sensor's signal chain at a programmed target. Each line carries a run of shielded pixels, and the timing logic marks that run with a window strobe. Inside the window the block sums the difference between every valid ADC sample and the black target. At the end of the window it turns that sum into a mean, passes the mean through a first-order low-pass step and adds the result to a signed correction word. That word drives an external correction DAC. A one-cycle strobe tells the DAC to latch each new value.

The target is set in quarter-LSB units, so the comparison keeps two fractional bits. Updates can be spaced out to one every N+1 lines. A disable input stops the servo. While it is set, the correction word simply follows the target register, so the block acts as a fixed programmable offset. Windows shorter than 20 pixels are accepted but give noisier corrections. A window with no valid samples changes nothing.

Top module: `blc_servo`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `corr_o` is 0 and `corr_valid_o` is 0.
- R2: A sample contributes only in a cycle where both `clamp_win_i` and `sample_valid_i` are 1. Its error in quarter-LSB units is 4*`sample_i` - `black_ref_i`, where `sample_i` is unsigned and `black_ref_i` is unsigned with 2 fractional bits (0 to 63.75 LSB).
- R3: At the end of a window the summed error is arithmetically shifted right by floor(log2(n)), where n is the number of contributing samples.
- R4: The correction is updated as corr = corr + (mean >>> `gain_shift_i`), where `gain_shift_i` ranges from 0 to 7 and the shift is arithmetic.
- R5: The correction is a 10-bit two's complement value that saturates at 511 and -512.
- R6: An update takes effect at the first clock edge at which `clamp_win_i` is sampled low after being high. `corr_valid_o` is 1 for exactly that one cycle, and only if the value changed.
- R7: Updates are armed on every (`line_div_i`+1)-th `line_start_i` pulse after reset. The first `line_start_i` after reset arms when `line_div_i` is 0. Each window end consumes the arming.
- R8: While `loop_off_i` is 1, the correction equals `black_ref_i` zero-extended, one cycle later. Windows do not change it. After `loop_off_i` returns to 0, the servo continues from that value.
- R9: A window with no contributing sample leaves the correction unchanged and gives no `corr_valid_o` pulse.
- R10: The sample count saturates at 1023. Samples after the 1023rd in the same window are ignored.
- R11: A window that ends while no update is armed is discarded, and the correction is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 10 | Unsigned ADC sample |
| sample_valid_i | input | 1 | Sample present this cycle |
| clamp_win_i | input | 1 | High over the shielded black pixels |
| line_start_i | input | 1 | One-cycle pulse at each line start |
| black_ref_i | input | 8 | Black target, quarter-LSB units |
| loop_off_i | input | 1 | Stop the servo; output follows target |
| gain_shift_i | input | 3 | Filter shift K |
| line_div_i | input | 4 | Update every line_div_i+1 lines |
| corr_o | output | 10 | Signed correction word for the DAC |
| corr_valid_o | output | 1 | One-cycle pulse when corr_o changes |

## Verification
Some properties are checked on every cycle:
- the correction stays still outside armed window ends;
- every valid pulse marks a real change;
- the disabled output tracks the target;
- the count clears after a window end;
- the sum freezes once the count is full;
- arming only follows a line pulse.

The bench's scenarios have to show the rest: the numeric result of the mean, shift and saturation for particular sample patterns, the line spacing, and that gap cycles and excess samples are ignored.

// File: rtl/blc_pkg.sv
package blc_pkg;

    // Floor of log2 for a positive value; 0 for 0 or 1.
    function automatic int floor_log2(input logic [31:0] v);
        int r;
        r = 0;
        for (int i = 1; i < 32; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/blc_err_accum.sv
module blc_err_accum #(
    parameter int SAMPLE_W = 10,
    parameter int REF_W    = 8,
    parameter int REF_FRAC = 2,
    parameter int CNT_W    = 10,
    localparam int ERR_W   = SAMPLE_W + REF_FRAC + 1,
    localparam int ACC_W   = ERR_W + CNT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SAMPLE_W-1:0]      sample_i,
    input  logic                     sample_valid_i,
    input  logic                     clamp_win_i,
    input  logic [REF_W-1:0]         black_ref_i,
    input  logic                     loop_off_i,
    output logic signed [ACC_W-1:0]  acc_o,
    output logic [CNT_W-1:0]         cnt_o,
    output logic                     win_end_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic             win;
    } acc_st_t;

    acc_st_t st_q, st_d;
    logic [ERR_W-1:0] err;
    logic             win_end;

    assign err = {1'b0, sample_i, {REF_FRAC{1'b0}}}
               - {{(ERR_W-REF_W){1'b0}}, black_ref_i};
    assign win_end = st_q.win & ~clamp_win_i;

    always_comb begin
        st_d     = st_q;
        st_d.win = clamp_win_i & ~loop_off_i;
        if (loop_off_i || win_end) begin
            st_d.acc = '0;
            st_d.cnt = '0;
        end else if (clamp_win_i && sample_valid_i && st_q.cnt != CNT_MAX) begin
            st_d.acc = st_q.acc + {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o     = $signed(st_q.acc);
    assign cnt_o     = st_q.cnt;
    assign win_end_o = win_end;

    // R9: a window end leaves an empty count for the next window
    a_r9_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        win_end_o |=> cnt_o == '0);

    // R10: a full count freezes the sum for the rest of the window
    a_r10_sum_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && clamp_win_i && !loop_off_i && st_q.win) |=> $stable(acc_o));

endmodule

// File: rtl/blc_line_pacer.sv
module blc_line_pacer #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start_i,
    input  logic [DIV_W-1:0] line_div_i,
    input  logic             consume_i,
    output logic             armed_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             armed;
    } pace_st_t;

    pace_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (consume_i) st_d.armed = 1'b0;
        if (line_start_i) begin
            if (st_q.cnt == line_div_i) begin
                st_d.cnt   = '0;
                st_d.armed = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;

    // R7: arming only ever follows a line pulse
    a_r7_arm_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> $past(line_start_i));

endmodule

// File: rtl/blc_iir_update.sv
module blc_iir_update #(
    parameter int ACC_W  = 23,
    parameter int CNT_W  = 10,
    parameter int CORR_W = 10,
    parameter int REF_W  = 8,
    parameter int K_W    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire_i,
    input  logic                    loop_off_i,
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic [K_W-1:0]          gain_shift_i,
    input  logic [REF_W-1:0]        black_ref_i,
    output logic [CORR_W-1:0]       corr_o,
    output logic                    corr_valid_o
);

    localparam int SUM_W   = ACC_W + 1;
    localparam int CORR_HI = (1 << (CORR_W - 1)) - 1;
    localparam int CORR_LO = -(1 << (CORR_W - 1));

    typedef struct packed {
        logic [CORR_W-1:0] corr;
        logic              vld;
    } iir_st_t;

    iir_st_t st_q, st_d;
    logic signed [ACC_W-1:0] mean;
    logic signed [ACC_W-1:0] step;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        mean = acc_i >>> blc_pkg::floor_log2(32'(cnt_i));
        step = mean >>> gain_shift_i;
        sum  = $signed({step[ACC_W-1], step})
             + $signed({{(SUM_W-CORR_W){st_q.corr[CORR_W-1]}}, st_q.corr});
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (loop_off_i) begin
            st_d.corr = CORR_W'(black_ref_i);
        end else if (fire_i && cnt_i != '0) begin
            if (sum > $signed(SUM_W'(CORR_HI)))      st_d.corr = CORR_W'(CORR_HI);
            else if (sum < $signed(SUM_W'(CORR_LO))) st_d.corr = CORR_W'(CORR_LO);
            else                                     st_d.corr = sum[CORR_W-1:0];
        end
        st_d.vld = (st_d.corr != st_q.corr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign corr_o       = st_q.corr;
    assign corr_valid_o = st_q.vld;

    // R6: each valid pulse marks an actual change of the word
    a_r6_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid_o |-> corr_o != $past(corr_o));

    // R11: no armed window end and servo running: the word holds
    a_r11_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire_i && !loop_off_i) |=> $stable(corr_o));

endmodule

// File: rtl/blc_servo.sv
module blc_servo #(
    parameter int SAMPLE_W = 10,
    parameter int REF_W    = 8,
    parameter int REF_FRAC = 2,
    parameter int CNT_W    = 10,
    parameter int CORR_W   = 10,
    parameter int K_W      = 3,
    parameter int DIV_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                sample_valid_i,
    input  logic                clamp_win_i,
    input  logic                line_start_i,
    input  logic [REF_W-1:0]    black_ref_i,
    input  logic                loop_off_i,
    input  logic [K_W-1:0]      gain_shift_i,
    input  logic [DIV_W-1:0]    line_div_i,
    output logic [CORR_W-1:0]   corr_o,
    output logic                corr_valid_o
);

    localparam int ERR_W = SAMPLE_W + REF_FRAC + 1;
    localparam int ACC_W = ERR_W + CNT_W;

    logic signed [ACC_W-1:0] acc;
    logic [CNT_W-1:0]        cnt;
    logic                    win_end;
    logic                    armed;
    logic                    fire;

    blc_err_accum #(
        .SAMPLE_W (SAMPLE_W),
        .REF_W    (REF_W),
        .REF_FRAC (REF_FRAC),
        .CNT_W    (CNT_W)
    ) u_accum (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_i       (sample_i),
        .sample_valid_i (sample_valid_i),
        .clamp_win_i    (clamp_win_i),
        .black_ref_i    (black_ref_i),
        .loop_off_i     (loop_off_i),
        .acc_o          (acc),
        .cnt_o          (cnt),
        .win_end_o      (win_end)
    );

    blc_line_pacer #(
        .DIV_W (DIV_W)
    ) u_pacer (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start_i),
        .line_div_i   (line_div_i),
        .consume_i    (win_end),
        .armed_o      (armed)
    );

    assign fire = win_end & armed & ~loop_off_i;

    blc_iir_update #(
        .ACC_W  (ACC_W),
        .CNT_W  (CNT_W),
        .CORR_W (CORR_W),
        .REF_W  (REF_W),
        .K_W    (K_W)
    ) u_iir (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire_i       (fire),
        .loop_off_i   (loop_off_i),
        .acc_i        (acc),
        .cnt_i        (cnt),
        .gain_shift_i (gain_shift_i),
        .black_ref_i  (black_ref_i),
        .corr_o       (corr_o),
        .corr_valid_o (corr_valid_o)
    );

    // R8: when stopped, the word tracks the target one cycle later
    a_r8_off_tracks_ref: assert property (@(posedge clk) disable iff (!rst_n)
        loop_off_i |=> corr_o == CORR_W'($past(black_ref_i)));

endmodule

// File: tb/sim_blc_servo.sv
module sim_blc_servo;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic [7:0]  ref_v;
        logic [2:0]  k;
        logic [9:0]  samp;
        logic [10:0] n;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{8'd64,  3'd0, 10'd20,   11'd4},
        '{8'd64,  3'd1, 10'd10,   11'd20},
        '{8'd100, 3'd2, 10'd30,   11'd7},
        '{8'd255, 3'd0, 10'd0,    11'd1},
        '{8'd0,   3'd3, 10'd100,  11'd32},
        '{8'd128, 3'd7, 10'd33,   11'd16},
        '{8'd0,   3'd0, 10'd1023, 11'd2},
        '{8'd255, 3'd0, 10'd0,    11'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] sample_i = '0;
    logic       sample_valid_i = 1'b0;
    logic       clamp_win_i = 1'b0;
    logic       line_start_i = 1'b0;
    logic [7:0] black_ref_i = '0;
    logic       loop_off_i = 1'b0;
    logic [2:0] gain_shift_i = '0;
    logic [3:0] line_div_i = '0;
    logic [9:0] corr_o;
    logic       corr_valid_o;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blc_servo u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_i       (sample_i),
        .sample_valid_i (sample_valid_i),
        .clamp_win_i    (clamp_win_i),
        .line_start_i   (line_start_i),
        .black_ref_i    (black_ref_i),
        .loop_off_i     (loop_off_i),
        .gain_shift_i   (gain_shift_i),
        .line_div_i     (line_div_i),
        .corr_o         (corr_o),
        .corr_valid_o   (corr_valid_o)
    );

    function automatic int next_corr(int c, int samp, int rv, int k, int n);
        int ne, err, sum, sh, mean, st, r;
        ne = (n > 1023) ? 1023 : n;
        if (ne == 0) return c;
        err = samp * 4 - rv;
        sum = ne * err;
        sh = 0;
        for (int i = 1; i < 11; i++) if ((ne >> i) != 0) sh = i;
        mean = sum >>> sh;
        st = mean >>> k;
        r = c + st;
        if (r > 511) r = 511;
        if (r < -512) r = -512;
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int corr_int();
        return int'($signed(corr_o));
    endfunction

    // One line: optional line pulse, then a window of n samples,
    // each optionally preceded by a gap cycle carrying junk data.
    task automatic run_line(input int samp, input int n, input bit gap,
                            input bit with_line);
        @(negedge clk);
        line_start_i = with_line;
        @(negedge clk);
        line_start_i = 1'b0;
        clamp_win_i  = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (gap) begin
                sample_valid_i = 1'b0;
                sample_i       = 10'd1023;
                @(negedge clk);
            end
            sample_valid_i = 1'b1;
            sample_i       = samp[9:0];
            @(negedge clk);
        end
        if (n == 0) repeat (5) @(negedge clk);
        sample_valid_i = 1'b0;
        clamp_win_i    = 1'b0;
        @(negedge clk);
    endtask

    // After run_line: update visible now; pulse only this cycle.
    task automatic check_after(input string tag, input int exp);
        int old;
        old = model;
        chk(tag, corr_int(), exp);
        chk({tag, " pulse"}, int'(corr_valid_o), int'(exp != old));
        model = exp;
        @(negedge clk);
        chk({tag, " pulse width"}, int'(corr_valid_o), 0);
    endtask

    initial begin
        int e;
        repeat (3) @(negedge clk);
        chk("R1 corr in reset", corr_int(), 0);
        chk("R1 valid in reset", int'(corr_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 corr after reset", corr_int(), 0);
        chk("R1 valid after reset", int'(corr_valid_o), 0);

        // Table of stimulus vectors (R2 R3 R4 R5 R6)
        foreach (TBL[i]) begin
            black_ref_i  = TBL[i].ref_v;
            gain_shift_i = TBL[i].k;
            e = next_corr(model, int'(TBL[i].samp), int'(TBL[i].ref_v),
                          int'(TBL[i].k), int'(TBL[i].n));
            run_line(int'(TBL[i].samp), int'(TBL[i].n), 1'b0, 1'b1);
            check_after("R3 R4 R6 table vector", e);
        end

        // R5: drive to the negative limit
        black_ref_i  = 8'd255;
        gain_shift_i = 3'd0;
        for (int j = 0; j < 3; j++) begin
            e = next_corr(model, 0, 255, 0, 1);
            run_line(0, 1, 1'b0, 1'b1);
            check_after("R5 negative saturation", e);
        end
        chk("R5 floor value", corr_int(), -512);

        // R2: gap cycles with junk data are ignored
        black_ref_i = 8'd40;
        e = next_corr(model, 60, 40, 0, 8);
        run_line(60, 8, 1'b1, 1'b1);
        check_after("R2 valid-gated samples", e);

        // R9: window without samples
        run_line(0, 0, 1'b0, 1'b1);
        check_after("R9 empty window", model);

        // R10: count saturates at 1023
        black_ref_i = 8'd0;
        e = next_corr(model, 5, 0, 0, 1100);
        run_line(5, 1100, 1'b0, 1'b1);
        check_after("R10 count cap", e);

        // R7 / R11: every second line
        line_div_i  = 4'd1;
        black_ref_i = 8'd200;
        run_line(10, 4, 1'b0, 1'b1);
        check_after("R11 unarmed window", model);
        e = next_corr(model, 10, 200, 0, 4);
        run_line(10, 4, 1'b0, 1'b1);
        check_after("R7 armed on second line", e);
        line_div_i = 4'd0;

        // R11: window with no line pulse before it
        run_line(200, 4, 1'b0, 1'b0);
        check_after("R11 window without line", model);

        // R8: disabled output follows the target
        @(negedge clk);
        loop_off_i  = 1'b1;
        black_ref_i = 8'd17;
        @(negedge clk);
        check_after("R8 off loads target", 17);
        run_line(900, 8, 1'b0, 1'b1);
        check_after("R8 window ignored when off", 17);
        black_ref_i = 8'd200;
        @(negedge clk);
        check_after("R8 target change", 200);
        loop_off_i = 1'b0;
        @(negedge clk);
        e = next_corr(model, 60, 200, 0, 4);
        run_line(60, 4, 1'b0, 1'b1);
        check_after("R8 resume from target", e);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule